// File: doc/BRIEF.md
# EEE Transmit Low-Power Idle Controller

This block decides when an Ethernet transmit MAC should stop sending normal idle and start signalling Low Power Idle (LPI) to its link partner. It watches a transmit-pending indication, counts consecutive clock cycles with nothing to send, and raises an LPI request toward the transmit datapath once that count is larger than a programmable 12-bit threshold. An immediate-entry mode skips the timer and requests LPI in the first cycle with nothing pending.

An LPI request is only ever made when Energy Efficient Ethernet is usable at the current link speed. For each speed (100M and 1G) software chooses where that ability comes from: either the flag reported by a PHY polling unit, or a software-forced value. A registered status flag reports whether EEE is currently usable on an up link. Software programs the block through a small write port with two registers.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge `lpi_req` and `eee_active` are driven to 0, the idle count is cleared, the control register is cleared and the threshold register is set to 0xFFF.
- R2: With immediate mode off, if `tx_pending` is low at N consecutive clock edges (with no other clearing condition), `lpi_req` is 1 after edge N exactly when N > threshold; threshold 0 gives entry after the first idle edge, threshold 0xFFF after edge 4096.
- R3: With immediate mode on, `lpi_req` is 1 after any edge at which nothing is pending, EEE is usable, the link is up, the speed is unchanged and no threshold write occurs, whatever the threshold.
- R4: Write address 0 loads the threshold from `cfg_wr_data[11:0]`; address 1 loads control: bit 0 immediate mode, bit 1 force-mode 100M, bit 2 force-mode 1G, bit 3 force-value 100M, bit 4 force-value 1G. For each speed, ability is the force value when its force-mode bit is set, else the PHY flag (`phy_eee_abl` bit 0 = 100M, bit 1 = 1G). `link_speed` 0 = 100M, 1 = 1G. A control write governs behaviour from the edge after the write edge.
- R5: `lpi_req` is never 1 unless, at the edge that set it, EEE ability for the current speed was active and `link_up` was high; `eee_active` is that same condition registered at every edge.
- R6: A `tx_pending` high at an edge clears the idle count and makes `lpi_req` 0 after that edge.
- R7: `link_up` low, or a `link_speed` value different from the previous edge, clears the idle count and makes `lpi_req` 0 after that edge.
- R8: The idle count saturates at its maximum and never wraps, so `lpi_req` stays 1 for as long as the line stays idle.
- R9: A threshold write clears the idle count at the write edge, and the new threshold is used for the count that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register address (0 threshold, 1 control) |
| cfg_wr_data | input | 16 | Register write data |
| tx_pending | input | 1 | High while the MAC has a frame to send |
| link_up | input | 1 | Link is up |
| link_speed | input | 1 | Current speed: 0 = 100M, 1 = 1G |
| phy_eee_abl | input | 2 | Polled EEE ability: bit 0 = 100M, bit 1 = 1G |
| lpi_req | output | 1 | Request to the transmit side to signal LPI |
| eee_active | output | 1 | EEE usable on an up link at the current speed |

## Verification
Both outputs are registers fed from the inputs of the same cycle, so a change on `tx_pending`, `link_up`, `link_speed` or `phy_eee_abl` shows at the outputs one edge later, while a control write needs two edges (one to load the register, one for its effect); threshold entry is due after edge threshold+1 of an idle run. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, so each check sees exactly the rising edge that consumed its stimulus. Threshold boundaries are checked on both sides: one edge before the due edge the request must still be low.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_THRESH = 2'd0,
    REG_CTRL   = 2'd1
  } reg_addr_e;

  // control register: immediate bit at 0, then force-mode bits, then force values
  localparam int CTRL_IMM_BIT = 0;

endpackage

// File: rtl/eee_lpi_regs.sv
module eee_lpi_regs
  import eee_lpi_pkg::*;
#(
  parameter int THR_W   = 12,
  parameter int N_SPD   = 2,
  parameter int DATA_W  = 16,
  parameter logic [THR_W-1:0] THR_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [THR_W-1:0]  thr_q,
  output logic              imm_q,
  output logic [N_SPD-1:0]  fmode_q,
  output logic [N_SPD-1:0]  fval_q,
  output logic              thr_wr
);

  localparam int CTRL_W = 1 + 2 * N_SPD;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;

  always_comb begin
    thr_wr  = wr_en && (wr_addr == REG_THRESH);
    ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= THR_RST;
      ctrl_q <= '0;
    end else begin
      if (thr_wr)  thr_q  <= wr_data[THR_W-1:0];
      if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  always_comb begin
    imm_q   = ctrl_q[CTRL_IMM_BIT];
    fmode_q = ctrl_q[N_SPD:1];
    fval_q  = ctrl_q[2*N_SPD:N_SPD+1];
  end

endmodule

// File: rtl/eee_ability_sel.sv
module eee_ability_sel #(
  parameter int N_SPD = 2,
  localparam int SPD_W = (N_SPD > 1) ? $clog2(N_SPD) : 1
) (
  input  logic [N_SPD-1:0] fmode,
  input  logic [N_SPD-1:0] fval,
  input  logic [N_SPD-1:0] phy_abl,
  input  logic [SPD_W-1:0] speed,
  output logic             active
);

  logic [N_SPD-1:0] abl;

  for (genvar s = 0; s < N_SPD; s++) begin : g_speed
    assign abl[s] = fmode[s] ? fval[s] : phy_abl[s];
  end

  always_comb begin
    active = 1'b0;
    for (int s = 0; s < N_SPD; s++) begin
      if (speed == SPD_W'(s)) active = abl[s];
    end
  end

endmodule

// File: rtl/eee_idle_timer.sv
module eee_idle_timer #(
  parameter int THR_W = 12,
  localparam int CNT_W = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [THR_W-1:0] thr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (clear)                cnt_nxt = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt = CNT_MAX;
    else                      cnt_nxt = cnt_q + 1'b1;
    expire = cnt_nxt > CNT_W'(thr);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int N_SPD  = 2,
  parameter int DATA_W = 16,
  localparam int SPD_W = (N_SPD > 1) ? $clog2(N_SPD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [DATA_W-1:0] cfg_wr_data,
  input  logic              tx_pending,
  input  logic              link_up,
  input  logic [SPD_W-1:0]  link_speed,
  input  logic [N_SPD-1:0]  phy_eee_abl,
  output logic              lpi_req,
  output logic              eee_active
);

  localparam int CNT_W = THR_W + 1;

  logic [THR_W-1:0] thr_q;
  logic             imm_q;
  logic [N_SPD-1:0] fmode_q;
  logic [N_SPD-1:0] fval_q;
  logic             thr_wr;
  logic             abl_now;
  logic [SPD_W-1:0] speed_q;
  logic             speed_chg;
  logic             clr;
  logic             expire;
  logic [CNT_W-1:0] idle_cnt;
  logic             lpi_d;

  eee_lpi_regs #(
    .THR_W  (THR_W),
    .N_SPD  (N_SPD),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .thr_q   (thr_q),
    .imm_q   (imm_q),
    .fmode_q (fmode_q),
    .fval_q  (fval_q),
    .thr_wr  (thr_wr)
  );

  eee_ability_sel #(
    .N_SPD (N_SPD)
  ) i_abl (
    .fmode   (fmode_q),
    .fval    (fval_q),
    .phy_abl (phy_eee_abl),
    .speed   (link_speed),
    .active  (abl_now)
  );

  // previous speed is tracked even in reset so a change is seen from the first edge
  always_ff @(posedge clk) speed_q <= link_speed;

  always_comb begin
    speed_chg = (link_speed != speed_q);
    clr       = tx_pending || !link_up || speed_chg || thr_wr || !abl_now;
    lpi_d     = !clr && (imm_q || expire);
  end

  eee_idle_timer #(
    .THR_W (THR_W)
  ) i_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (clr),
    .thr    (thr_q),
    .cnt_q  (idle_cnt),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lpi_req    <= 1'b0;
      eee_active <= 1'b0;
    end else begin
      lpi_req    <= lpi_d;
      eee_active <= abl_now && link_up;
    end
  end

endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk #(
  parameter int CNT_W = 13,
  parameter int SPD_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_pending,
  input logic             link_up,
  input logic [SPD_W-1:0] link_speed,
  input logic             lpi_req,
  input logic             eee_active,
  input logic             imm,
  input logic             abl_now,
  input logic             thr_wr,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R5
  lpi_only_when_active_chk: assert property (@(posedge clk) disable iff (rst)
    lpi_req |-> eee_active);

  // R6
  pending_drops_lpi_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pending |=> (!lpi_req && cnt == '0));

  // R7
  link_down_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!lpi_req && cnt == '0));

  // R7
  speed_change_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (link_speed != $past(link_speed)) |=> !lpi_req);

  // R3
  imm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (imm && abl_now && link_up && !tx_pending && !thr_wr &&
     link_speed == $past(link_speed)) |=> lpi_req);

  // R8
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == CNT_MAX));

  // R9
  thr_wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> cnt == '0);

endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk #(
  .CNT_W (THR_W + 1),
  .SPD_W (SPD_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_pending (tx_pending),
  .link_up    (link_up),
  .link_speed (link_speed),
  .lpi_req    (lpi_req),
  .eee_active (eee_active),
  .imm        (imm_q),
  .abl_now    (abl_now),
  .thr_wr     (thr_wr),
  .cnt        (idle_cnt)
);

// File: tb/test_eee_lpi_ctrl.sv
`timescale 1ns/1ps
module test_eee_lpi_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_addr = 2'd0;
  logic [15:0] cfg_wr_data = 16'd0;
  logic        tx_pending = 1'b1;
  logic        link_up = 1'b1;
  logic        link_speed = 1'b1;
  logic [1:0]  phy_eee_abl = 2'b11;
  logic        lpi_req;
  logic        eee_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  eee_lpi_ctrl i_eee_lpi_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .tx_pending  (tx_pending),
    .link_up     (link_up),
    .link_speed  (link_speed),
    .phy_eee_abl (phy_eee_abl),
    .lpi_req     (lpi_req),
    .eee_active  (eee_active)
  );

  // {pending, link_up, speed, phy 1G, phy 100M, expected lpi_req, expected eee_active}
  // threshold 2, control 0
  localparam logic [6:0] VEC [0:19] = '{
    7'b1111101, 7'b0111101, 7'b0111101, 7'b0111111, 7'b0111111,
    7'b1111101, 7'b0111101, 7'b0111101, 7'b0111111, 7'b0101101,
    7'b0101101, 7'b0101101, 7'b0101111, 7'b0101000, 7'b0101000,
    7'b0101101, 7'b0101101, 7'b0101111, 7'b0001100, 7'b0101101
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [1:0] addr, input logic [15:0] data);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = addr;
    cfg_wr_data = data;
    tick(1);
    cfg_wr_en   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    check("R1 lpi_req in reset", lpi_req, 1'b0);
    check("R1 eee_active in reset", eee_active, 1'b0);
    rst = 1'b0;
    tick(1);
    cfg_write(2'd0, 16'd2);

    // R2 R5 R6 R7 vector table
    for (int i = 0; i < 20; i++) begin
      logic el, ea;
      {tx_pending, link_up, link_speed, phy_eee_abl[1], phy_eee_abl[0], el, ea} = VEC[i];
      tick(1);
      check($sformatf("R2 R5 R6 R7 step %0d lpi_req", i), lpi_req, el);
      check($sformatf("R5 step %0d eee_active", i), eee_active, ea);
    end

    // R9 threshold write restarts the count
    tx_pending = 1'b1; link_speed = 1'b1; phy_eee_abl = 2'b11;
    cfg_write(2'd0, 16'd5);
    tx_pending = 1'b0;
    tick(4);
    check("R9 before rewrite", lpi_req, 1'b0);
    cfg_write(2'd0, 16'd3);
    check("R9 at rewrite edge", lpi_req, 1'b0);
    tick(3);
    check("R9 count restarted", lpi_req, 1'b0);
    tick(1);
    check("R9 new threshold used", lpi_req, 1'b1);

    // R4 forced ability overrides polled flag
    tx_pending = 1'b1;
    cfg_write(2'd0, 16'd0);
    cfg_write(2'd1, 16'h0004);
    tx_pending = 1'b0;
    tick(3);
    check("R4 forced off lpi_req", lpi_req, 1'b0);
    check("R4 forced off eee_active", eee_active, 1'b0);
    phy_eee_abl = 2'b00;
    cfg_write(2'd1, 16'h0014);
    check("R4 write edge old control", eee_active, 1'b0);
    tick(1);
    check("R4 forced on eee_active", eee_active, 1'b1);
    check("R4 forced on lpi_req", lpi_req, 1'b1);
    phy_eee_abl = 2'b01;
    link_speed = 1'b0;
    tick(1);
    check("R4 100M follows phy", eee_active, 1'b1);
    check("R7 speed change drops", lpi_req, 1'b0);

    // R3 immediate mode ignores a large threshold
    tx_pending = 1'b1; link_speed = 1'b1; phy_eee_abl = 2'b11;
    cfg_write(2'd0, 16'h0FFF);
    cfg_write(2'd1, 16'h0001);
    tick(1);
    check("R3 pending keeps low", lpi_req, 1'b0);
    tx_pending = 1'b0;
    tick(1);
    check("R3 immediate entry", lpi_req, 1'b1);
    tx_pending = 1'b1;
    tick(1);
    check("R6 pending exits", lpi_req, 1'b0);
    tx_pending = 1'b0;
    phy_eee_abl = 2'b01;
    tick(1);
    check("R5 immediate blocked without ability", lpi_req, 1'b0);

    // R2 threshold zero
    tx_pending = 1'b1; phy_eee_abl = 2'b11;
    cfg_write(2'd1, 16'h0000);
    cfg_write(2'd0, 16'h0000);
    tick(1);
    tx_pending = 1'b0;
    tick(1);
    check("R2 threshold zero entry", lpi_req, 1'b1);

    // R2 R8 largest threshold and saturation
    tx_pending = 1'b1;
    cfg_write(2'd0, 16'h0FFF);
    tx_pending = 1'b0;
    tick(4095);
    check("R2 max threshold not yet", lpi_req, 1'b0);
    tick(1);
    check("R2 max threshold entry", lpi_req, 1'b1);
    tick(5000);
    check("R8 saturated count holds", lpi_req, 1'b1);

    // R1 reset mid-run
    rst = 1'b1;
    tick(1);
    check("R1 lpi_req after reset", lpi_req, 1'b0);
    check("R1 eee_active after reset", eee_active, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule